// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block generates the instruction fetch address for a single-issue pipeline in which every control transfer has one delay slot. The execute stage reports each cycle whether the instruction it is working on is a jump, a conditional branch, whether that branch is taken, and the jump target or branch offset. An instruction fetched in cycle t executes in cycle t+1. A transfer that executes in cycle t leaves the fetch of cycle t alone, because that fetch is its delay slot, and sets the fetch address of cycle t+1. The same rule holds when a transfer sits in the delay slot of another transfer, so two back-to-back jumps interleave their targets. A common use is to run a single instruction somewhere else and then continue at a second address.

The sequencer keeps a two-entry address queue. One entry holds the address of the instruction now executing and the other holds the address now being fetched. An exception saves both entries together and sends fetch to a fixed vector. A return replays both saved addresses in order, so an interrupted pair of adjacent transfers restarts exactly where it stopped. A build-time option adds a flag that fires when a control transfer executes in the delay slot of another one. Surrounding logic can use that flag to raise an illegal-instruction trap.

Top module: `fetch_seq`

## Requirements
- R1: After reset the fetch address equals RESET_VEC (default 0x100) and the slot flag is low.
- R2: When no transfer, exception or return acts in a cycle, the next fetch address is the current fetch address plus 4.
- R3: A jump that executes in cycle t leaves the fetch address of cycle t unchanged and makes the fetch address of cycle t+1 equal to its absolute target. If the jump and branch inputs are both high, the jump input wins.
- R4: A taken branch that executes in cycle t makes the fetch address of cycle t+1 equal to the fetch address of cycle t (its delay slot) plus the signed byte offset. A branch that is not taken behaves as in R2.
- R5: When a jump sits in the delay slot of another jump, the fetch stream interleaves the two targets. A jump to T followed by a jump to L fetches T once and then continues at L.
- R6: An exception strobe makes the next fetch address EXC_VEC (default 0x80). It overrides a return strobe and any transfer in the same cycle. Taken in normal running, it saves the executing address and the fetching address as a pair.
- R7: In the cycle after an exception, the executing instruction is discarded: any transfer it reports is ignored, and fetch advances by 4 from EXC_VEC.
- R8: A return strobe without an exception makes the next fetch the first saved address. The fetch after that is the second saved address, and any transfer reported in between is ignored. After that the stream continues as if it had never been interrupted.
- R9: With the slot option enabled, the flag is high in exactly those cycles where a jump or branch is acted on and the cycle before also acted on a jump or branch. Discarded or overridden transfers do not count.
- R10: With the slot option disabled (the default), the flag stays low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_jump | input | 1 | Executing instruction is an unconditional jump |
| ex_branch | input | 1 | Executing instruction is a conditional branch |
| ex_taken | input | 1 | Condition of the executing branch is true |
| ex_jump_target | input | AW | Absolute jump target address |
| ex_br_offset | input | AW | Signed byte offset, relative to the delay-slot address |
| exc_req | input | 1 | Exception strobe |
| exc_ret | input | 1 | Return-from-exception strobe |
| fetch_addr | output | AW | Address fetched in this cycle |
| slot_ctl_err | output | 1 | Transfer executed in a delay slot (optional) |

## Verification
The collisions that matter are an exception in the same cycle as a jump, and a reported transfer in one of the two cycles that follow an exception or a return. In those cycles the transfer must lose.

The bench places an exception on the second of two adjacent jumps, and again on the first of them. This makes the discarded and overridden transfers really present on the inputs. A jump is also placed at the handler address that is being executed during the replay cycle.

Each fetch address is compared with a hand-derived list. This confirms that the two-address replay rebuilds the interleaved stream and that none of the losing transfers leaks through. The slot flag is judged in the same runs, so that overridden transfers are shown not to count.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    // Operating mode of the address queue.
    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,  // normal: executing instruction may redirect
        MODE_KILL   = 2'd1,  // first cycle after an exception: executing op dropped
        MODE_RESUME = 2'd2   // first cycle after a return: second saved address next
    } seq_mode_e;

endpackage

// File: rtl/fseq_target.sv
// Resolves whether the executing instruction redirects fetch and where to.
module fseq_target #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] slot_addr,    // address being fetched = delay slot
    input  logic          is_jump,
    input  logic          is_branch,
    input  logic          taken,
    input  logic [AW-1:0] jump_target,
    input  logic [AW-1:0] br_offset,
    output logic          redirect,
    output logic [AW-1:0] dest
);

    logic [AW-1:0] br_dest;

    always_comb begin
        br_dest  = slot_addr + br_offset;
        redirect = is_jump | (is_branch & taken);
        dest     = is_jump ? jump_target : br_dest;
    end

endmodule

// File: rtl/fseq_epc_bank.sv
// Holds the saved pair of queue addresses across an exception.
module fseq_epc_bank #(
    parameter int            AW    = 32,
    parameter logic [AW-1:0] INIT  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [AW-1:0] save_cur,
    input  logic [AW-1:0] save_fet,
    output logic [AW-1:0] epc0,
    output logic [AW-1:0] epc1
);

    typedef struct packed {
        logic [AW-1:0] first;
        logic [AW-1:0] second;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (save_en) begin
            pair_d.first  = save_cur;
            pair_d.second = save_fet;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '{first: INIT, second: INIT};
        end else begin
            pair_q <= pair_d;
        end
    end

    assign epc0 = pair_q.first;
    assign epc1 = pair_q.second;

endmodule

// File: rtl/fseq_slot_mon.sv
// Detects a control transfer acted on directly after another one.
module fseq_slot_mon #(
    parameter bit EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_live,   // a jump or branch is acted on this cycle
    output logic err
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = ctl_live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    generate
        if (EN) begin : g_flag_on
            assign err = ctl_live & prev_q;
        end else begin : g_flag_off
            assign err = ctl_live & prev_q & 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fseq_pkg::*;
#(
    parameter int            AW           = 32,
    parameter logic [AW-1:0] RESET_VEC    = 'h100,
    parameter logic [AW-1:0] EXC_VEC      = 'h80,
    parameter int            ISTEP        = 4,
    parameter bit            SLOT_FLAG_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_jump,
    input  logic          ex_branch,
    input  logic          ex_taken,
    input  logic [AW-1:0] ex_jump_target,
    input  logic [AW-1:0] ex_br_offset,
    input  logic          exc_req,
    input  logic          exc_ret,
    output logic [AW-1:0] fetch_addr,
    output logic          slot_ctl_err
);

    localparam logic [AW-1:0] STEP = AW'(ISTEP);

    typedef struct packed {
        logic [AW-1:0] cur;   // address of instruction in execute
        logic [AW-1:0] fet;   // address being fetched
        seq_mode_e     mode;
    } queue_t;

    queue_t        q_d, q_q;
    logic          in_run, in_resume;
    logic          live, redirect, save_en;
    logic [AW-1:0] dest, epc0, epc1, seq_next;

    assign in_run    = (q_q.mode == MODE_RUN);
    assign in_resume = (q_q.mode == MODE_RESUME);
    assign live      = in_run & ~exc_req & ~exc_ret;
    assign save_en   = exc_req & in_run;

    fseq_target #(.AW(AW)) u_target (
        .slot_addr   (q_q.fet),
        .is_jump     (ex_jump),
        .is_branch   (ex_branch),
        .taken       (ex_taken),
        .jump_target (ex_jump_target),
        .br_offset   (ex_br_offset),
        .redirect    (redirect),
        .dest        (dest)
    );

    fseq_epc_bank #(.AW(AW), .INIT(RESET_VEC)) u_epc (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (save_en),
        .save_cur (q_q.cur),
        .save_fet (q_q.fet),
        .epc0     (epc0),
        .epc1     (epc1)
    );

    fseq_slot_mon #(.EN(SLOT_FLAG_EN)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_live (live & (ex_jump | ex_branch)),
        .err      (slot_ctl_err)
    );

    always_comb begin
        seq_next = q_q.fet + STEP;
        q_d      = q_q;
        q_d.cur  = q_q.fet;
        if (exc_req) begin
            q_d.fet  = EXC_VEC;
            q_d.mode = MODE_KILL;
        end else if (exc_ret) begin
            q_d.fet  = epc0;
            q_d.mode = MODE_RESUME;
        end else if (in_resume) begin
            q_d.fet  = epc1;
            q_d.mode = MODE_RUN;
        end else if (in_run) begin
            q_d.fet  = redirect ? dest : seq_next;
            q_d.mode = MODE_RUN;
        end else begin
            q_d.fet  = seq_next;
            q_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '{cur: RESET_VEC, fet: RESET_VEC, mode: MODE_RUN};
        end else begin
            q_q <= q_d;
        end
    end

    assign fetch_addr = q_q.fet;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] EXC_VEC = 'h80,
    parameter int            ISTEP   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ex_jump,
    input logic          ex_branch,
    input logic          ex_taken,
    input logic [AW-1:0] ex_jump_target,
    input logic [AW-1:0] ex_br_offset,
    input logic          exc_req,
    input logic          exc_ret,
    input logic [AW-1:0] fetch_addr,
    input logic          slot_ctl_err,
    input logic          in_run,
    input logic          in_resume,
    input logic [AW-1:0] epc0,
    input logic [AW-1:0] epc1
);

    // R2 and R7: straight-line advance when nothing redirects
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !exc_ret && !in_resume &&
         !(in_run && (ex_jump || (ex_branch && ex_taken))))
        |=> fetch_addr == $past(fetch_addr) + AW'(ISTEP));

    // R3: jump lands one cycle after it executes
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !exc_req && !exc_ret && ex_jump)
        |=> fetch_addr == $past(ex_jump_target));

    // R4: taken branch is relative to its delay slot
    a_r4_branch_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !exc_req && !exc_ret && !ex_jump && ex_branch && ex_taken)
        |=> fetch_addr == $past(fetch_addr) + $past(ex_br_offset));

    // R6: exception vectors and leaves normal running
    a_r6_exc_vector: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (fetch_addr == EXC_VEC) && !in_run);

    // R8: return replays first saved address, then second
    a_r8_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && !exc_req) |=> in_resume && fetch_addr == $past(epc0));

    a_r8_ret_second: assert property (@(posedge clk) disable iff (!rst_n)
        (in_resume && !exc_req && !exc_ret) |=> fetch_addr == $past(epc1));

    // R9: flag only for an acted-on transfer
    a_r9_flag_live: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ctl_err |-> in_run && !exc_req && !exc_ret && (ex_jump || ex_branch));

endmodule

bind fetch_seq fseq_chk #(.AW(AW), .EXC_VEC(EXC_VEC), .ISTEP(ISTEP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ex_jump        (ex_jump),
    .ex_branch      (ex_branch),
    .ex_taken       (ex_taken),
    .ex_jump_target (ex_jump_target),
    .ex_br_offset   (ex_br_offset),
    .exc_req        (exc_req),
    .exc_ret        (exc_ret),
    .fetch_addr     (fetch_addr),
    .slot_ctl_err   (slot_ctl_err),
    .in_run         (in_run),
    .in_resume      (in_resume),
    .epc0           (epc0),
    .epc1           (epc1)
);

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;

    localparam logic [31:0] RV = 32'h100;
    localparam logic [31:0] EV = 32'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_jump = 1'b0, ex_branch = 1'b0, ex_taken = 1'b0;
    logic [31:0] ex_jump_target = '0, ex_br_offset = '0;
    logic        exc_req = 1'b0, exc_ret = 1'b0;
    logic [31:0] fetch_addr, fa_nf;
    logic        slot_ctl_err, flag_nf;

    always #2 clk = ~clk;

    fetch_seq #(.AW(32), .RESET_VEC(RV), .EXC_VEC(EV), .SLOT_FLAG_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ex_jump(ex_jump), .ex_branch(ex_branch),
        .ex_taken(ex_taken), .ex_jump_target(ex_jump_target), .ex_br_offset(ex_br_offset),
        .exc_req(exc_req), .exc_ret(exc_ret), .fetch_addr(fetch_addr),
        .slot_ctl_err(slot_ctl_err)
    );

    fetch_seq #(.AW(32), .RESET_VEC(RV), .EXC_VEC(EV)) u_dut_nf (
        .clk(clk), .rst_n(rst_n), .ex_jump(ex_jump), .ex_branch(ex_branch),
        .ex_taken(ex_taken), .ex_jump_target(ex_jump_target), .ex_br_offset(ex_br_offset),
        .exc_req(exc_req), .exc_ret(exc_ret), .fetch_addr(fa_nf),
        .slot_ctl_err(flag_nf)
    );

    int          checks = 0, fails = 0;
    bit          done = 1'b0;
    int          prog_id = 0, sw_kind = 0, sw_tk = 0;
    logic [31:0] sw_val = '0;
    int          exc_at = -1, ret_at = -1;
    logic [31:0] exp_a [0:19];
    bit          exp_f [0:19];

    function automatic logic [31:0] waddr(input int w);
        return RV + 32'(4 * w);
    endfunction

    // Program memory: kind of instruction stored at an address.
    task automatic decode(input logic [31:0] a, output bit j, output bit b,
                          output bit tk, output logic [31:0] v);
        int w;
        w  = int'(a - RV) / 4;
        j  = 0; b = 0; tk = 0; v = '0;
        if (a == EV + 32'd8) begin j = 1; v = 32'h40; end
        else if (a >= RV) begin
            case (prog_id)
                0: begin
                    j = (w <= 6);
                    case (w)
                        0: v = waddr(3); 1: v = waddr(2); 2: v = waddr(3);
                        3: v = waddr(4); 4: v = waddr(5); 5: v = waddr(6);
                        default: v = waddr(7);
                    endcase
                end
                1: begin
                    if (w == 0) begin j = 1; v = waddr(8); end
                    if (w == 1) begin j = 1; v = waddr(2); end
                end
                2: begin
                    if (w == 0) begin b = 1; tk = 1; v = 32'd16; end
                    if (w == 5) begin b = 1; tk = 0; v = 32'd100; end
                    if (w == 7) begin b = 1; tk = 1; v = -32'sd8; end
                end
                default: begin
                    if (w == 0) begin
                        j = (sw_kind == 0); b = (sw_kind == 1); tk = sw_tk[0]; v = sw_val;
                    end
                end
            endcase
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ex_jump = 0; ex_branch = 0; ex_taken = 0; exc_req = 0; exc_ret = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input string req, input int n);
        logic [31:0] prev = '0;
        bit j, b, tk;
        logic [31:0] v;
        do_reset();
        for (int c = 0; c < n; c++) begin
            if (c > 0) @(negedge clk);
            if (c > 0) decode(prev, j, b, tk, v);
            else begin j = 0; b = 0; tk = 0; v = '0; end
            ex_jump = j; ex_branch = b; ex_taken = tk;
            ex_jump_target = v; ex_br_offset = v;
            exc_req = (c == exc_at); exc_ret = (c == ret_at);
            #1;
            if (c == 0) begin
                chk("R1 reset fetch", fetch_addr, RV);
                chk("R1 reset flag", {31'b0, slot_ctl_err}, 32'd0);
            end else begin
                chk(req, fetch_addr, exp_a[c]);
                chk("R9 slot flag", {31'b0, slot_ctl_err}, {31'b0, exp_f[c]});
            end
            chk("R10 flag disabled", {31'b0, flag_nf}, 32'd0);
            prev = fetch_addr;
        end
        @(negedge clk);
        ex_jump = 0; ex_branch = 0; ex_taken = 0; exc_req = 0; exc_ret = 0;
        exc_at = -1; ret_at = -1;
    endtask

    task automatic set_exp(input int ws[], input int flag_lo, input int flag_hi);
        foreach (ws[i]) exp_a[i] = waddr(ws[i]);
        for (int i = 0; i < 20; i++) exp_f[i] = (i >= flag_lo && i <= flag_hi);
    endtask

    initial begin
        // R5 chained jumps: each jump sits in the previous one's slot
        prog_id = 0;
        set_exp('{0,1,3,2,4,3,5,4,6,5,7,6,7,7,8,9,10}, 2, 10);
        run("R5 chained jumps", 17);

        // R5 two-jump single-instruction idiom
        prog_id = 1;
        set_exp('{0,1,8,2,3,4}, 2, 2);
        run("R5 execute idiom", 6);

        // R4 branches, taken forward, not taken, taken backward loop
        prog_id = 2;
        set_exp('{0,1,5,6,7,8,6,7,8,6}, 99, 0);
        run("R4 branch stream", 10);

        // R6 R8 exception on second of adjacent jumps, then return
        prog_id = 1; exc_at = 2; ret_at = 5;
        set_exp('{0,1,8,-32,-31,-30,1,8,2,3}, 99, 0);
        run("R6 R8 exc between jumps", 10);

        // R7 exception on first jump: killed jump ignored, replay rebuilds stream
        prog_id = 1; exc_at = 1; ret_at = 3;
        set_exp('{0,1,-32,-31,0,1,8,2,3}, 6, 6);
        run("R7 R8 kill and replay", 9);

        // R4 sweep of branch offsets and conditions
        prog_id = 3; sw_kind = 1;
        for (int off = -8; off <= 8; off++) begin
            for (int tk = 0; tk < 2; tk++) begin
                sw_tk = tk; sw_val = 32'(off * 4);
                exp_a[1] = waddr(1);
                exp_a[2] = tk ? waddr(1 + off) : waddr(2);
                exp_a[3] = exp_a[2] + 32'd4;
                for (int i = 0; i < 20; i++) exp_f[i] = 1'b0;
                run("R4 branch sweep", 4);
            end
        end

        // R3 sweep of jump targets, plus R2 advance after landing
        sw_kind = 0;
        for (int t = 0; t < 16; t++) begin
            sw_val = 32'h200 + 32'(4 * t);
            exp_a[1] = waddr(1);
            exp_a[2] = sw_val;
            exp_a[3] = sw_val + 32'd4;
            for (int i = 0; i < 20; i++) exp_f[i] = 1'b0;
            run("R3 jump sweep", 4);
        end

        // R2 plain sequential stream
        prog_id = 5; sw_kind = 2;
        set_exp('{0,1,2,3,4,5,6,7}, 99, 0);
        run("R2 sequential", 8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule